// File: doc/BRIEF.md
# Fault Flag Encoder with Serial Fault Readout

This block gathers the fault conditions of a three-phase gate driver and reports them on two open-drain fault flags. The inputs are the short detections on the three low-side switches, supply undervoltage, internal-logic undervoltage, and overtemperature. The two flags form a two-bit code. A release of the flag means "fault present", because the external pull-up then makes the wire read high. A driven-low flag means "no fault" for that bit. The block also produces the disable-all command for the bridge.

The block keeps a five-bit latched fault word. An external controller can read this word through the same two wires. While flag 2 is released, the controller pulls flag 2 low to clock the readout, and each falling edge presents the next word bit on flag 1. A sixth falling edge ends the read and clears the word and the latched flags. Any fault that is still live appears on the flags again at once.

Each pad is modelled as an output enable (1 = drive the wire low) plus, for flag 2, an input sense of the wire level. The flag 2 sense is synchronized into the system clock, and falling edges are counted only while the block itself has released that wire. All other fault inputs are synchronous to the clock. Outputs are registered, so they change one clock after the inputs that cause them.

Top module: `fltflag_top`

## Requirements
- R1: A flag reads "set" when its output enable is 0 (released) and "clear" when it is 1 (driven low). The code (flag 1, flag 2) is: clear/clear for no fault, clear/set for a latched low-side short, set/clear for overtemperature, and set/set for supply or internal-logic undervoltage.
- R2: When several faults are present at once, each flag is set if any present fault sets it.
- R3: A short pulse on any low-side input latches the matching word bit and keeps flag 2 set until the word is cleared.
- R4: Supply undervoltage sets both flags only while present, and it latches the supply bit (word position 4) until the word is cleared.
- R5: Overtemperature sets flag 1 only while present. Nothing of it is latched.
- R6: `disable_all` is high one clock after internal-logic undervoltage, or supply undervoltage, or overtemperature with `stop_on_fault` high. It is low one clock after none of these holds.
- R7: While flag 2 is released, the k-th falling edge on the flag 2 wire (k = 1..5) makes flag 1 show word position k-1, with a released flag meaning 1. The positions are: 0 power-on, 1 phase A low short, 2 phase B low short, 3 phase C low short, 4 supply undervoltage.
- R8: Whenever the block drives flag 2 low, a read in progress is abandoned. The next read starts at word position 0.
- R9: The sixth falling edge clears the word and the latched flags. Faults that are still live show on the flags again in the same clock.
- R10: Internal-logic undervoltage sets both flags, ends any read, and leaves the word holding only the power-on bit.
- R11: A low level on `clr_n` clears the word and the latched flags.
- R12: After reset both flags are driven low, `disable_all` is low, and the word holds only the power-on bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Active-low fault-word clear pulse |
| ls_short | input | 3 | Low-side short detections, bit 0 = phase A |
| vsup_uv | input | 1 | Supply undervoltage present |
| vlogic_uv | input | 1 | Internal logic supply undervoltage present |
| ovt | input | 1 | Overtemperature present |
| stop_on_fault | input | 1 | Overtemperature also disables all outputs |
| flag2_in | input | 1 | Sensed level of the flag 2 wire |
| flag1_oe | output | 1 | Flag 1 pull-low enable |
| flag2_oe | output | 1 | Flag 2 pull-low enable |
| disable_all | output | 1 | Turn every bridge switch off |

## Verification
The bench reads a word that holds a mix of ones and zeros, which exposes a wrong bit order or a counter that is off by one edge. It also reads after the sixth edge, so a design that clears only the flags but keeps the word would return stale short bits. One read is cut short when the supply fault goes away and is then restarted. A counter that survives the abort would shift the word by two positions and clear it too early. Other checks cover the one-shot short pulse, which must stay latched, and an overtemperature entry followed by a quiet entry, which shows whether overtemperature was wrongly latched. Further checks cover the stop-on-fault gating and the priority of internal-logic undervoltage, which rewrites the word to the power-on bit only.

// File: rtl/fltflag_pkg.sv
package fltflag_pkg;
    localparam int NUM_PH   = 3;
    localparam int REG_W    = NUM_PH + 2;
    localparam int POR_IDX  = 0;
    localparam int VC_IDX   = REG_W - 1;
    localparam int CNT_W    = $clog2(REG_W + 2);
    localparam logic [REG_W-1:0] POR_ONLY = REG_W'(1) << POR_IDX;
endpackage

// File: rtl/fl_fall_det.sv
module fl_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    input  logic released,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
        logic [STAGES:0]   rel;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pad_in};
        st_d.prev = st_q.sync[STAGES-1];
        st_d.rel  = {st_q.rel[STAGES-1:0], released};
    end

    // an edge only counts if the block itself released the wire over the whole sync window
    assign fall = st_q.prev & ~st_q.sync[STAGES-1] & (&st_q.rel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fl_fault_reg.sv
module fl_fault_reg
    import fltflag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe_all,
    input  logic             clear,
    input  logic [REG_W-1:0] set_bits,
    output logic [REG_W-1:0] bits_d,
    output logic [REG_W-1:0] bits_q
);
    always_comb begin
        if (wipe_all) bits_d = POR_ONLY;
        else          bits_d = (clear ? '0 : bits_q) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= POR_ONLY;
        else        bits_q <= bits_d;
    end
endmodule

// File: rtl/fl_readout.sv
module fl_readout
    import fltflag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             fall,
    output logic             done,
    output logic [CNT_W-1:0] cnt_d,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W);

    always_comb begin
        cnt_d = cnt_q;
        done  = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (fall) begin
            if (cnt_q == LAST) begin
                cnt_d = '0;
                done  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fltflag_top.sv
module fltflag_top
    import fltflag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic [NUM_PH-1:0] ls_short,
    input  logic              vsup_uv,
    input  logic              vlogic_uv,
    input  logic              ovt,
    input  logic              stop_on_fault,
    input  logic              flag2_in,
    output logic              flag1_oe,
    output logic              flag2_oe,
    output logic              disable_all
);
    typedef struct packed {
        logic f1_oe;
        logic f2_oe;
        logic dis;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             f2_fall;
    logic             rd_done;
    logic             rd_restart;
    logic [CNT_W-1:0] rd_cnt_d, rd_cnt;
    logic [REG_W-1:0] set_vec, word_d, word_q;
    logic             word_clear;

    fl_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (flag2_in),
        .released (~st_q.f2_oe),
        .fall     (f2_fall)
    );

    assign rd_restart = st_q.f2_oe | vlogic_uv | ~clr_n;

    fl_readout u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rd_restart),
        .fall    (f2_fall),
        .done    (rd_done),
        .cnt_d   (rd_cnt_d),
        .cnt_q   (rd_cnt)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[VC_IDX]  = vsup_uv;
        for (int ph = 0; ph < NUM_PH; ph++) set_vec[1+ph] = ls_short[ph];
    end

    assign word_clear = ~clr_n | rd_done;

    fl_fault_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe_all (vlogic_uv),
        .clear    (word_clear),
        .set_bits (set_vec),
        .bits_d   (word_d),
        .bits_q   (word_q)
    );

    logic short_lat, f1_set, f2_set, rd_bit;

    always_comb begin
        st_d      = st_q;
        short_lat = 1'b0;
        for (int ph = 0; ph < NUM_PH; ph++) short_lat |= word_d[1+ph];
        f1_set    = ovt | vsup_uv | vlogic_uv;
        f2_set    = short_lat | vsup_uv | vlogic_uv;
        rd_bit    = 1'b0;
        for (int i = 0; i < REG_W; i++) begin
            if (rd_cnt_d == CNT_W'(i + 1)) rd_bit = word_d[i];
        end
        st_d.f2_oe = ~f2_set;
        st_d.f1_oe = (rd_cnt_d != '0) ? ~rd_bit : ~f1_set;
        st_d.dis   = vlogic_uv | vsup_uv | (ovt & stop_on_fault);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{f1_oe: 1'b1, f2_oe: 1'b1, dis: 1'b0};
        else        st_q <= st_d;
    end

    assign flag1_oe    = st_q.f1_oe;
    assign flag2_oe    = st_q.f2_oe;
    assign disable_all = st_q.dis;
endmodule

// File: rtl/fltflag_chk.sv
module fltflag_chk
    import fltflag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_PH-1:0] ls_short,
    input logic              vsup_uv,
    input logic              vlogic_uv,
    input logic              ovt,
    input logic              stop_on_fault,
    input logic              flag1_oe,
    input logic              flag2_oe,
    input logic              disable_all,
    input logic [CNT_W-1:0]  rd_cnt
);
    // R6
    dis_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vlogic_uv || vsup_uv || (ovt && stop_on_fault)) |=> disable_all);
    // R6
    dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vlogic_uv || vsup_uv || (ovt && stop_on_fault)) |=> !disable_all);
    // R10
    logic_uv_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vlogic_uv |=> (!flag1_oe && !flag2_oe && rd_cnt == '0));
    // R4
    supply_uv_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsup_uv |=> (!flag2_oe && (rd_cnt != '0 || !flag1_oe)));
    // R3
    short_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ls_short) |=> !flag2_oe);
    // R5
    ovt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovt |=> (rd_cnt != '0 || !flag1_oe));
    // R8
    read_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag2_oe |=> rd_cnt == '0);
endmodule

bind fltflag_top fltflag_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ls_short      (ls_short),
    .vsup_uv       (vsup_uv),
    .vlogic_uv     (vlogic_uv),
    .ovt           (ovt),
    .stop_on_fault (stop_on_fault),
    .flag1_oe      (flag1_oe),
    .flag2_oe      (flag2_oe),
    .disable_all   (disable_all),
    .rd_cnt        (rd_cnt)
);

// File: tb/tb_fltflag_top.sv
module tb_fltflag_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_n = 1'b1;
    logic [2:0] ls_short = '0;
    logic       vsup_uv = 1'b0, vlogic_uv = 1'b0, ovt = 1'b0, stop_on_fault = 1'b0;
    logic       ctl_low = 1'b0;
    logic       flag1_oe, flag2_oe, disable_all;
    logic       flag2_wire;
    int         n_chk = 0, n_bad = 0;
    bit         ended = 1'b0;

    always #2 clk = ~clk;

    assign flag2_wire = ~(flag2_oe | ctl_low);

    fltflag_top dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ls_short(ls_short),
        .vsup_uv(vsup_uv), .vlogic_uv(vlogic_uv), .ovt(ovt),
        .stop_on_fault(stop_on_fault), .flag2_in(flag2_wire),
        .flag1_oe(flag1_oe), .flag2_oe(flag2_oe), .disable_all(disable_all)
    );

    // {ovt, stop_on_fault, vsup_uv, vlogic_uv, flag1 set, flag2 set, disable}
    localparam logic [6:0] VEC [8] = '{
        7'b0000_000, 7'b1000_100, 7'b1100_101, 7'b0100_000,
        7'b0010_111, 7'b0001_111, 7'b1010_111, 7'b0000_000
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_bits(input int n, input logic [4:0] exp, input string req);
        for (int i = 0; i < n; i++) begin
            ctl_low = 1'b1;
            ticks(4);
            check(req, {7'd0, ~flag1_oe}, {7'd0, exp[i]});
            ctl_low = 1'b0;
            ticks(4);
        end
    endtask

    task automatic end_read(input logic f1_set, input logic f2_set, input string req);
        ctl_low = 1'b1;
        ticks(4);
        check(req, {6'd0, ~flag1_oe, ~flag2_oe}, {6'd0, f1_set, f2_set});
        ctl_low = 1'b0;
        ticks(4);
    endtask

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(1);
        // R12 reset state
        check("R12", {5'd0, flag1_oe, flag2_oe, disable_all}, 8'b110);
        vsup_uv = 1'b1;
        ticks(4);
        read_bits(5, 5'b10001, "R12");
        end_read(1'b1, 1'b1, "R9");
        vsup_uv = 1'b0;
        ticks(2);

        // table: R1 R2 R5 R6 R10
        foreach (VEC[k]) begin
            {ovt, stop_on_fault, vsup_uv, vlogic_uv} = VEC[k][6:3];
            ticks(1);
            check("R1/R2 flag1", {7'd0, ~flag1_oe}, {7'd0, VEC[k][2]});
            check("R1/R2 flag2", {7'd0, ~flag2_oe}, {7'd0, VEC[k][1]});
            check("R6", {7'd0, disable_all}, {7'd0, VEC[k][0]});
        end

        // R11 clear pulse
        clr_n = 1'b0; ticks(1); clr_n = 1'b1; ticks(1);

        // R10 logic undervoltage
        vlogic_uv = 1'b1; ticks(1);
        check("R10", {6'd0, flag1_oe, flag2_oe}, 8'b00);
        vlogic_uv = 1'b0; ticks(1);
        check("R10 release", {6'd0, flag1_oe, flag2_oe}, 8'b11);

        // R3 one-cycle short pulse on phase B latches
        ls_short = 3'b010; ticks(1); ls_short = 3'b000;
        check("R3", {6'd0, flag1_oe, flag2_oe}, 8'b10);
        ticks(6);
        check("R3 held", {6'd0, flag1_oe, flag2_oe}, 8'b10);

        // R4 supply undervoltage pulse
        vsup_uv = 1'b1; ticks(1);
        check("R4 live", {6'd0, flag1_oe, flag2_oe}, 8'b00);
        vsup_uv = 1'b0; ticks(1);
        check("R4 gone", {6'd0, flag1_oe, flag2_oe}, 8'b10);

        // R7 order: por=1 A=0 B=1 C=0 VC=1
        ticks(3);
        read_bits(5, 5'b10101, "R7");
        end_read(1'b0, 1'b0, "R9 clear");

        // R9 cleared word, R4 latched VC, live fault reappears
        vsup_uv = 1'b1; ticks(4);
        read_bits(5, 5'b10000, "R9/R4");
        end_read(1'b1, 1'b1, "R9 reappear");

        // R8 abort mid-read
        read_bits(2, 5'b00000, "R8 part");
        vsup_uv = 1'b0; ticks(2);
        check("R8 driven", {7'd0, flag2_oe}, 8'd1);
        ticks(4);
        vsup_uv = 1'b1; ticks(4);
        read_bits(5, 5'b10000, "R8 restart");
        end_read(1'b1, 1'b1, "R8 end");
        vsup_uv = 1'b0; ticks(2);

        // R11 clear removes latched short
        ls_short = 3'b100; ticks(1); ls_short = 3'b000;
        check("R11 pre", {7'd0, flag2_oe}, 8'd0);
        clr_n = 1'b0; ticks(1); clr_n = 1'b1; ticks(1);
        check("R11", {6'd0, flag1_oe, flag2_oe}, 8'b11);

        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule